// File: doc/BRIEF.md
# I2S Sample FIFO and Status Controller

This block sits between a processor register bus and a stereo I2S serializer. Software writes outgoing samples into a 32-entry transmit queue and reads incoming samples from a 32-entry receive queue, each through its own data word. The serializer takes transmit samples through a pop strobe and hands back receive samples through a push strobe. A config word holds a master enable, a DMA-request enable, one enable per direction and a 4-bit watermark per direction. A second config word selects an internal loopback, in which every sample the serializer pops is stored straight into the receive queue.

Eight sticky event flags record four events per direction: the watermark was crossed, the queue ran dry, the queue overflowed, or the data word was accessed while the block was off. Software clears a flag by writing a 1 to it. An interrupt line reports any flag that is also set in an enable mask. A level-sensitive DMA request tells a bus master when the transmit queue needs more data or the receive queue holds enough to drain. Writing the config word with the master enable at 0 restores every control field to its default value and empties both queues.

Top module: `i2s_fifo_ctrl`

## Requirements
- R1: After reset, the registers read as follows: config word (offset 0x00) 0x0000_4040, with both watermarks at 4; event flags (0x04) 0; interrupt mask (0x08) 0; queue-level word (0x0C) 0x0F; transmit data offset (0x10) 0; loopback word (0x18) 0. `irq` and `dma_req` are low.
- R2: Words written at 0x10 while the master enable is on enter the transmit queue. The head of the queue is shown on `tx_sample` whenever transmit is enabled. Each `tx_pop` with the master enable and transmit enable both on advances the queue. A write while 32 words are held is dropped and sets flag bit 2.
- R3: A `tx_pop` with the master enable and transmit enable on, while the transmit queue is empty, sets flag bit 1 and shows a zero sample. `tx_sample` is zero whenever transmit is disabled.
- R4: An `rx_push` with the master enable and receive enable on stores `rx_sample`, or drops it and sets flag bit 6 if 32 words are held. A read at 0x14 returns the oldest word and removes it. A read of an empty queue returns 0 and sets flag bit 5.
- R5: While the master enable is off, a write at 0x10 sets flag bit 3, and a read at 0x14 returns 0 and sets flag bit 7. Neither access changes either queue.
- R6: Writing 1s at 0x04 clears those flags, and 0 bits leave their flags unchanged. A flag that is being set in the same cycle stays set.
- R7: Flag bit 0 is set in every cycle in which the master and transmit enables are on and the transmit count is at or below the transmit watermark (config bits 7:4). Flag bit 4 is set in every cycle in which the master and receive enables are on and the receive count is at or above the receive watermark (bits 15:12).
- R8: The queue-level word holds the transmit free space in bits 3:0 and the receive fill count in bits 7:4, each capped at 15.
- R9: `irq` is high exactly when some flag bit and the same interrupt-mask bit are both 1.
- R10: `dma_req` is high when the master enable and the DMA enable (bit 30) are on and either the transmit enable (bit 24) is on with the transmit count at or below its watermark, or the receive enable (bit 20) is on with the receive count at or above its watermark.
- R11: A config-word write with bit 31 at 0 sets the config word to its defaults and clears the loopback bit and the interrupt mask, and it empties both queues in the same cycle. While the master enable is off, writes at 0x08 and 0x18 are ignored. A config-word write with bit 31 at 1 loads the enables and watermarks.
- R12: With loopback on (bit 31 at 0x18), each accepted `tx_pop` pushes the popped sample, or zero on underrun, into the receive queue under the receive rules. The external `rx_push` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read at 0x14 pops the receive queue) |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| tx_pop | input | 1 | Serializer takes the current transmit sample |
| tx_sample | output | 32 | Head of the transmit queue, or zero |
| rx_push | input | 1 | Serializer offers a received sample |
| rx_sample | input | 32 | Received sample |
| dma_req | output | 1 | Level-sensitive DMA service request |
| irq | output | 1 | Masked OR of the event flags |

## Verification
A corrupted queue pointer or count appears at the ports within one cycle. It shows up as the wrong sample on `tx_sample` or in the data read at 0x14, as a wrong queue-level word, or as a DMA request at the wrong level. A flag that is set wrongly or cleared wrongly shows on `irq` in the cycle after the event once its mask bit is on. A config field that fails to return to its default shows on the next read of 0x00, 0x08 or 0x18. The most telling cases are: a queue that is full while a write arrives, an empty queue that is popped, a flag that is cleared and set in the same cycle, and the disable write that empties both queues while traffic is running.

// File: rtl/i2s_fifo_pkg.sv
`timescale 1ns/1ps
package i2s_fifo_pkg;
  localparam int REG_W = 32;
  localparam int ADDR_W = 8;
  localparam int EV_N = 8;

  localparam logic [ADDR_W-1:0] OFF_CFG0  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_ISTAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_IEN   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_FSTAT = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_TXD   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_RXD   = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_CFG1  = 8'h18;

  localparam int B_EN = 31;
  localparam int B_DMA = 30;
  localparam int B_TXEN = 24;
  localparam int B_RXEN = 20;
  localparam int RXTHR_LSB = 12;
  localparam int TXTHR_LSB = 4;
  localparam int B_LOOP = 31;
  localparam logic [3:0] THR_DEFAULT = 4'd4;

  // event flag positions (receive = transmit + 4)
  localparam int EV_TX_THR = 0;
  localparam int EV_TX_UNR = 1;
  localparam int EV_TX_OVR = 2;
  localparam int EV_TX_FLT = 3;
  localparam int EV_RX_THR = 4;
  localparam int EV_RX_UNR = 5;
  localparam int EV_RX_OVR = 6;
  localparam int EV_RX_FLT = 7;

  typedef struct packed {
    logic       en;
    logic       dma;
    logic       tx_en;
    logic       rx_en;
    logic [3:0] rx_thr;
    logic [3:0] tx_thr;
  } ctl_t;

  function automatic ctl_t ctl_default();
    ctl_t c;
    c.en = 1'b0;
    c.dma = 1'b0;
    c.tx_en = 1'b0;
    c.rx_en = 1'b0;
    c.rx_thr = THR_DEFAULT;
    c.tx_thr = THR_DEFAULT;
    return c;
  endfunction

  function automatic ctl_t ctl_unpack(input logic [REG_W-1:0] w);
    ctl_t c;
    c.en = w[B_EN];
    c.dma = w[B_DMA];
    c.tx_en = w[B_TXEN];
    c.rx_en = w[B_RXEN];
    c.rx_thr = w[RXTHR_LSB +: 4];
    c.tx_thr = w[TXTHR_LSB +: 4];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] ctl_pack(input ctl_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[B_EN] = c.en;
    w[B_DMA] = c.dma;
    w[B_TXEN] = c.tx_en;
    w[B_RXEN] = c.rx_en;
    w[RXTHR_LSB +: 4] = c.rx_thr;
    w[TXTHR_LSB +: 4] = c.tx_thr;
    return w;
  endfunction

  // cap a count into a 4-bit field
  function automatic logic [3:0] sat_nibble(input logic [15:0] n);
    return (n > 16'd15) ? 4'hF : n[3:0];
  endfunction

  function automatic logic at_or_below(input logic [15:0] n, input logic [3:0] thr);
    return n <= {12'b0, thr};
  endfunction

  function automatic logic at_or_above(input logic [15:0] n, input logic [3:0] thr);
    return n >= {12'b0, thr};
  endfunction
endpackage

// File: rtl/i2s_sample_fifo.sv
`timescale 1ns/1ps
module i2s_sample_fifo #(
  parameter int DW = 32,
  parameter int DEPTH = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic do_push, do_pop;

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop = pop && !empty && !flush;
  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count <= '0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop) rd_ptr <= next_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10: count <= count + CW'(1);
        2'b01: count <= count - CW'(1);
        default: ;
      endcase
    end
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop && !flush |=> count == $past(count));
endmodule

// File: rtl/i2s_evt_status.sv
`timescale 1ns/1ps
module i2s_evt_status #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] st
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= '0;
    else st <= (st & ~clr) | set;
  end

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> (st & $past(set)) == $past(set));

  // R6
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~set)) |=> (st & $past(clr & ~set)) == '0);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (st & $past(st & ~clr)) == $past(st & ~clr));
endmodule

// File: rtl/i2s_ctl_regs.sv
`timescale 1ns/1ps
module i2s_ctl_regs
  import i2s_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cfg0,
  input  logic             wr_cfg1,
  input  logic             wr_ien,
  input  logic [REG_W-1:0] wdata,
  output ctl_t             ctl,
  output logic             loop_en,
  output logic [EV_N-1:0]  ien,
  output logic             en_next
);
  ctl_t ctl_d;
  logic loop_d;
  logic [EV_N-1:0] ien_d;

  always_comb begin
    ctl_d = ctl;
    loop_d = loop_en;
    ien_d = ien;
    if (wr_cfg0) begin
      if (wdata[B_EN]) begin
        ctl_d = ctl_unpack(wdata);
      end else begin
        ctl_d = ctl_default();
        loop_d = 1'b0;
        ien_d = '0;
      end
    end else if (ctl.en) begin
      if (wr_cfg1) loop_d = wdata[B_LOOP];
      if (wr_ien) ien_d = wdata[EV_N-1:0];
    end
  end

  assign en_next = ctl_d.en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= ctl_default();
      loop_en <= 1'b0;
      ien <= '0;
    end else begin
      ctl <= ctl_d;
      loop_en <= loop_d;
      ien <= ien_d;
    end
  end

  // R11
  off_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en |=> (ien == '0) && !loop_en);
endmodule

// File: rtl/i2s_fifo_ctrl.sv
`timescale 1ns/1ps
module i2s_fifo_ctrl
  import i2s_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              tx_pop,
  output logic [REG_W-1:0]  tx_sample,
  input  logic              rx_push,
  input  logic [REG_W-1:0]  rx_sample,
  output logic              dma_req,
  output logic              irq
);
  ctl_t ctl;
  logic loop_en, en_next, flush;
  logic [EV_N-1:0] ien, st, ev, clr;

  logic tx_wr_hit, rx_rd_hit;
  logic tx_pop_ok, tx_full, tx_empty, tx_lvl;
  logic rx_src, rx_push_ok, rx_full, rx_empty, rx_lvl, lb_on;
  logic [REG_W-1:0] tx_head, rx_head, rx_in, rx_rd_data;
  logic [CW-1:0] tx_cnt, rx_cnt;

  assign tx_wr_hit = reg_wr && (reg_addr == OFF_TXD);
  assign rx_rd_hit = reg_rd && (reg_addr == OFF_RXD);
  assign flush = !en_next;

  i2s_ctl_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_cfg0 (reg_wr && (reg_addr == OFF_CFG0)),
    .wr_cfg1 (reg_wr && (reg_addr == OFF_CFG1)),
    .wr_ien  (reg_wr && (reg_addr == OFF_IEN)),
    .wdata   (reg_wdata),
    .ctl     (ctl),
    .loop_en (loop_en),
    .ien     (ien),
    .en_next (en_next)
  );

  // transmit direction
  assign tx_pop_ok = tx_pop && ctl.en && ctl.tx_en;
  assign tx_sample = (ctl.en && ctl.tx_en && !tx_empty) ? tx_head : '0;

  i2s_sample_fifo #(.DW(REG_W), .DEPTH(DEPTH)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (tx_wr_hit && ctl.en),
    .push_data (reg_wdata),
    .pop       (tx_pop_ok),
    .head      (tx_head),
    .count     (tx_cnt),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  // receive direction, optionally fed by the transmit side
  assign lb_on = ctl.en && loop_en;
  assign rx_src = lb_on ? tx_pop_ok : rx_push;
  assign rx_in = lb_on ? tx_sample : rx_sample;
  assign rx_push_ok = rx_src && ctl.en && ctl.rx_en;
  assign rx_rd_data = (ctl.en && !rx_empty) ? rx_head : '0;

  i2s_sample_fifo #(.DW(REG_W), .DEPTH(DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (rx_push_ok),
    .push_data (rx_in),
    .pop       (rx_rd_hit && ctl.en),
    .head      (rx_head),
    .count     (rx_cnt),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  // watermark levels
  assign tx_lvl = ctl.tx_en && at_or_below(16'(tx_cnt), ctl.tx_thr);
  assign rx_lvl = ctl.rx_en && at_or_above(16'(rx_cnt), ctl.rx_thr);
  assign dma_req = ctl.en && ctl.dma && (tx_lvl || rx_lvl);

  // event vector
  always_comb begin
    ev = '0;
    ev[EV_TX_THR] = ctl.en && tx_lvl;
    ev[EV_TX_UNR] = tx_pop_ok && tx_empty;
    ev[EV_TX_OVR] = tx_wr_hit && ctl.en && tx_full;
    ev[EV_TX_FLT] = tx_wr_hit && !ctl.en;
    ev[EV_RX_THR] = ctl.en && rx_lvl;
    ev[EV_RX_UNR] = rx_rd_hit && ctl.en && rx_empty;
    ev[EV_RX_OVR] = rx_push_ok && rx_full;
    ev[EV_RX_FLT] = rx_rd_hit && !ctl.en;
  end

  assign clr = (reg_wr && (reg_addr == OFF_ISTAT)) ? reg_wdata[EV_N-1:0] : '0;

  i2s_evt_status #(.N(EV_N)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ev),
    .clr   (clr),
    .st    (st)
  );

  assign irq = |(st & ien);

  // register read mux
  always_comb begin
    case (reg_addr)
      OFF_CFG0:  reg_rdata = ctl_pack(ctl);
      OFF_ISTAT: reg_rdata = {{(REG_W-EV_N){1'b0}}, st};
      OFF_IEN:   reg_rdata = {{(REG_W-EV_N){1'b0}}, ien};
      OFF_FSTAT: reg_rdata = {{(REG_W-8){1'b0}}, sat_nibble(16'(rx_cnt)),
                              sat_nibble(16'(DEPTH - int'(tx_cnt)))};
      OFF_RXD:   reg_rdata = rx_rd_data;
      OFF_CFG1:  reg_rdata = {loop_en, {(REG_W-1){1'b0}}};
      default:   reg_rdata = '0;
    endcase
  end

  // R3
  underrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop_ok && tx_empty |=> st[EV_TX_UNR]);

  // R12
  loop_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lb_on && tx_pop_ok && ctl.rx_en && !rx_full && !rx_rd_hit && en_next
    |=> rx_cnt == $past(rx_cnt) + CW'(1));

  // R5
  fault_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en |=> (tx_cnt == '0) && (rx_cnt == '0));
endmodule

// File: tb/i2s_fifo_ctrl_tb.sv
`timescale 1ns/1ps
module i2s_fifo_ctrl_tb_top;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, reg_wr, reg_rd, tx_pop, rx_push, dma_req, irq;
  logic [7:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata, tx_sample, rx_sample;

  i2s_fifo_ctrl #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_pop(tx_pop), .tx_sample(tx_sample), .rx_push(rx_push),
    .rx_sample(rx_sample), .dma_req(dma_req), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  bit m_en, m_dma, m_txen, m_rxen, m_loop;
  logic [3:0] m_rxthr, m_txthr;
  logic [7:0] m_ien, m_st;
  logic [31:0] txq[$];
  logic [31:0] rxq[$];
  bit lit_en = 0;
  logic [31:0] lit_val;

  task automatic model_defaults();
    m_en = 0; m_dma = 0; m_txen = 0; m_rxen = 0; m_loop = 0;
    m_rxthr = 4'd4; m_txthr = 4'd4; m_ien = 8'h00;
    txq.delete(); rxq.delete();
  endtask

  function automatic logic [3:0] sat15(int n);
    return (n > 15) ? 4'hF : 4'(n);
  endfunction

  function automatic logic [31:0] model_read(logic [7:0] a);
    case (a)
      8'h00: return {m_en, m_dma, 5'b0, m_txen, 3'b0, m_rxen, 4'b0, m_rxthr, 4'b0, m_txthr, 4'b0};
      8'h04: return {24'b0, m_st};
      8'h08: return {24'b0, m_ien};
      8'h0C: return {24'b0, sat15(rxq.size()), sat15(DEPTH - txq.size())};
      8'h14: return (m_en && rxq.size() > 0) ? rxq[0] : 32'h0;
      8'h18: return {m_loop, 31'b0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit model_dma();
    return m_en && m_dma && ((m_txen && txq.size() <= int'(m_txthr)) ||
                             (m_rxen && rxq.size() >= int'(m_rxthr)));
  endfunction

  function automatic bit model_irq();
    return |(m_st & m_ien);
  endfunction

  task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock cycle of stimulus, checked against the model
  task automatic op(string tag, bit wr, bit rd, logic [7:0] a, logic [31:0] d,
                    bit pop, bit push, logic [31:0] smp);
    logic [31:0] exp_tx, lbd;
    logic [7:0] set, clr;
    bit pop_ok, src, lb;
    int txc, rxc;
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    tx_pop = pop; rx_push = push; rx_sample = smp;
    #1;
    txc = txq.size(); rxc = rxq.size();
    exp_tx = (m_en && m_txen && txc > 0) ? txq[0] : 32'h0;
    check32(tag, "tx_sample", tx_sample, exp_tx);
    if (rd) check32(tag, "rdata", reg_rdata, model_read(a));
    if (rd && lit_en) check32(tag, "rdata literal", reg_rdata, lit_val);
    check32(tag, "irq R9", {31'b0, irq}, {31'b0, model_irq()});
    check32(tag, "dma_req R10", {31'b0, dma_req}, {31'b0, model_dma()});
    // next state
    set = 0; clr = 0;
    if (m_en && m_txen && txc <= int'(m_txthr)) set[0] = 1;
    if (m_en && m_rxen && rxc >= int'(m_rxthr)) set[4] = 1;
    pop_ok = pop && m_en && m_txen;
    if (pop_ok) begin
      if (txc == 0) set[1] = 1;
      else void'(txq.pop_front());
    end
    if (wr && a == 8'h10) begin
      if (!m_en) set[3] = 1;
      else if (txc >= DEPTH) set[2] = 1;
      else txq.push_back(d);
    end
    lb = m_en && m_loop;
    src = lb ? pop_ok : push;
    lbd = lb ? exp_tx : smp;
    if (src && m_en && m_rxen) begin
      if (rxc >= DEPTH) set[6] = 1;
      else rxq.push_back(lbd);
    end
    if (rd && a == 8'h14) begin
      if (!m_en) set[7] = 1;
      else if (rxc == 0) set[5] = 1;
      else void'(rxq.pop_front());
    end
    if (wr && a == 8'h04) clr = d[7:0];
    m_st = (m_st & ~clr) | set;
    if (wr && a == 8'h00) begin
      if (d[31]) begin
        m_en = 1; m_dma = d[30]; m_txen = d[24]; m_rxen = d[20];
        m_rxthr = d[15:12]; m_txthr = d[7:4];
      end else model_defaults();
    end else if (m_en) begin
      if (wr && a == 8'h18) m_loop = d[31];
      if (wr && a == 8'h08) m_ien = d[7:0];
    end
    @(posedge clk);
  endtask

  task automatic idle(string tag);
    op(tag, 0, 0, 8'h00, 0, 0, 0, 0);
  endtask
  task automatic wr(string tag, logic [7:0] a, logic [31:0] d);
    op(tag, 1, 0, a, d, 0, 0, 0);
  endtask
  task automatic rd(string tag, logic [7:0] a);
    op(tag, 0, 1, a, 0, 0, 0, 0);
  endtask
  task automatic rd_lit(string tag, logic [7:0] a, logic [31:0] v);
    lit_en = 1; lit_val = v;
    op(tag, 0, 1, a, 0, 0, 0, 0);
    lit_en = 0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd31337);
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    tx_pop = 0; rx_push = 0; rx_sample = 0;
    model_defaults(); m_st = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset values
    rd_lit("R1", 8'h00, 32'h0000_4040);
    rd_lit("R1", 8'h04, 32'h0);
    rd_lit("R1", 8'h08, 32'h0);
    rd_lit("R1", 8'h0C, 32'h0000_000F);
    rd_lit("R1", 8'h10, 32'h0);
    rd_lit("R1", 8'h18, 32'h0);

    // R2 fill transmit queue past capacity
    wr("R2", 8'h00, 32'h8100_4040);
    for (int i = 0; i < 40; i++) wr("R2", 8'h10, 32'hA000 + i);
    rd_lit("R8", 8'h0C, 32'h0);
    rd_lit("R2", 8'h04, 32'h05);
    wr("R6", 8'h04, 32'hFF);
    rd_lit("R6", 8'h04, 32'h0);
    for (int i = 0; i < 32; i++) op("R2", 0, 0, 0, 0, 1, 0, 0);
    // R3 underrun on empty queue
    op("R3", 0, 0, 0, 0, 1, 0, 0);
    op("R3", 0, 0, 0, 0, 1, 0, 0);
    rd_lit("R3", 8'h04, 32'h03);
    wr("R6", 8'h04, 32'h02);
    rd_lit("R6", 8'h04, 32'h01);
    wr("R6", 8'h04, 32'h00);
    op("R6", 1, 0, 8'h04, 32'h02, 1, 0, 0);
    rd_lit("R6", 8'h04, 32'h03);

    // R4 receive queue overflow and drain
    wr("R4", 8'h00, 32'h8010_4040);
    wr("R4", 8'h04, 32'hFF);
    for (int i = 0; i < 34; i++) op("R4", 0, 0, 0, 0, 0, 1, 32'hB000 + i);
    rd_lit("R8", 8'h0C, 32'h0000_00FF);
    for (int i = 0; i < 33; i++) rd("R4", 8'h14);
    rd_lit("R4 R7", 8'h04, 32'h70);

    // R8 partial levels
    wr("R8", 8'h00, 32'h8110_4040);
    for (int i = 0; i < 20; i++) wr("R8", 8'h10, 32'hC000 + i);
    for (int i = 0; i < 5; i++) op("R8", 0, 0, 0, 0, 0, 1, 32'hD000 + i);
    rd_lit("R8", 8'h0C, 32'h0000_005C);

    // R11 disable empties queues and restores defaults
    wr("R11", 8'h00, 32'h0);
    rd_lit("R11", 8'h00, 32'h0000_4040);
    rd_lit("R11", 8'h0C, 32'h0000_000F);
    wr("R11", 8'h08, 32'hFF);
    rd_lit("R11", 8'h08, 32'h0);
    wr("R11", 8'h18, 32'h8000_0000);
    rd_lit("R11", 8'h18, 32'h0);

    // R5 faults while off
    wr("R5", 8'h04, 32'hFF);
    wr("R5", 8'h10, 32'h1234);
    rd_lit("R5", 8'h14, 32'h0);
    op("R5", 0, 0, 0, 0, 1, 1, 32'h55);
    rd_lit("R5", 8'h04, 32'h88);
    rd_lit("R5", 8'h0C, 32'h0000_000F);

    // R11 load then reset non-default fields
    wr("R11", 8'h00, 32'h8000_F010);
    rd_lit("R11", 8'h00, 32'h8000_F010);
    wr("R11", 8'h18, 32'h8000_0000);
    wr("R11", 8'h08, 32'h12);
    rd_lit("R11", 8'h08, 32'h12);
    wr("R11", 8'h00, 32'h0);
    rd_lit("R11", 8'h00, 32'h0000_4040);
    rd_lit("R11", 8'h18, 32'h0);
    rd_lit("R11", 8'h08, 32'h0);

    // R7 receive watermark
    wr("R7", 8'h00, 32'h8010_3040);
    wr("R7", 8'h04, 32'hFF);
    op("R7", 0, 0, 0, 0, 0, 1, 32'h1);
    op("R7", 0, 0, 0, 0, 0, 1, 32'h2);
    rd_lit("R7", 8'h04, 32'h0);
    op("R7", 0, 0, 0, 0, 0, 1, 32'h3);
    idle("R7");
    rd_lit("R7", 8'h04, 32'h10);
    wr("R7", 8'h00, 32'h0);

    // R9 interrupt masking
    wr("R9", 8'h00, 32'h8100_4040);
    wr("R9", 8'h04, 32'hFF);
    wr("R9", 8'h08, 32'h01);
    idle("R9");
    idle("R9");
    wr("R9", 8'h08, 32'h02);
    idle("R9");
    op("R9", 0, 0, 0, 0, 1, 0, 0);
    idle("R9");
    wr("R9", 8'h04, 32'h02);
    idle("R9");

    // R10 DMA request levels
    wr("R10", 8'h00, 32'hC100_4040);
    for (int i = 0; i < 6; i++) wr("R10", 8'h10, 32'hE000 + i);
    idle("R10");
    wr("R10", 8'h00, 32'h0);
    wr("R10", 8'h00, 32'hC010_2040);
    op("R10", 0, 0, 0, 0, 0, 1, 32'h77);
    op("R10", 0, 0, 0, 0, 0, 1, 32'h78);
    idle("R10");
    wr("R10", 8'h00, 32'h0);

    // R12 loopback
    wr("R12", 8'h00, 32'h8110_4040);
    wr("R12", 8'h18, 32'h8000_0000);
    for (int i = 0; i < 3; i++) wr("R12", 8'h10, 32'hF000 + i);
    for (int i = 0; i < 4; i++) op("R12", 0, 0, 0, 0, 1, 1, 32'hDEAD);
    for (int i = 0; i < 4; i++) rd("R12", 8'h14);
    op("R12", 0, 0, 0, 0, 0, 1, 32'hBEEF);
    rd_lit("R12", 8'h14, 32'h0);
    wr("R12", 8'h00, 32'h0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [31:0] d;
      logic [7:0] a;
      bit p, q;
      r = int'($urandom % 16);
      d = $urandom;
      p = ($urandom % 2) == 0;
      q = ($urandom % 3) == 0;
      case (r)
        0, 1, 2, 3: op("R2 R4 random", 1, 0, 8'h10, d, p, q, $urandom);
        4, 5, 6:    op("R4 R12 random", 0, 1, 8'h14, 0, p, q, $urandom);
        7: begin
          a = 8'(4 * ($urandom % 7));
          op("R8 R1 random", 0, 1, a, 0, p, q, $urandom);
        end
        8: op("R6 random", 1, 0, 8'h04, d, p, q, $urandom);
        9: begin
          if (($urandom % 8) != 0) d[31] = 1'b1;
          op("R11 random", 1, 0, 8'h00, d, p, q, $urandom);
        end
        10: op("R12 random", 1, 0, 8'h18, d, p, q, $urandom);
        11: op("R9 random", 1, 0, 8'h08, d, p, q, $urandom);
        default: op("R7 R10 random", 0, 0, 8'h00, 0, p, q, $urandom);
      endcase
    end
    idle("R1");

    done = 1;
    summary();
    $finish;
  end
endmodule